// File: doc/BRIEF.md
# Framed Bus Request Arbiter

This block decides which of up to 32 devices on a shared, frame-based cell bus may transmit in the coming frame. A frame is 16 clock cycles long and starts on a pulse of the frame sync input. Requests are taken from the devices only in the first cycle of a frame, as a request bit and a 2-bit priority level per device. In the last cycle of the frame the arbiter presents a one-hot grant, valid for that one cycle, naming the device that owns the next frame.

A mode input selects 16-device or 32-device operation. In 16-device operation every frame is self-contained: frame sync pulses every frame and only devices 0 to 15 take part. In 32-device operation frame sync pulses every second frame and marks the even frame. Devices 0 to 15 report in the even frame's request cycle and devices 16 to 31 in the odd frame's, which starts 16 cycles later. Both halves feed one common pool of pending requests. The highest priority level wins, and ties at one level are broken round-robin.

Top module: `frame_arbiter`

## Requirements
- R1: `mode` = 0 selects 16-device operation, in which each frame is arbitrated on its own and frame sync pulses at the start of every frame; `mode` = 1 selects 32-device operation.
- R2: The cycle in which `fsync` is high is cycle 0 of a frame, and a frame lasts 16 cycles. Until the first `fsync` after reset, no grant is ever issued.
- R3: Request and priority inputs are sampled only in cycle 0 of a frame; their values in every other cycle have no effect on any grant.
- R4: In 16-device operation the pending pool is replaced by `req[15:0]` and `prio[31:0]` at each request cycle, and `req[31:16]` and `prio[63:32]` are ignored, so no device above 15 is ever granted.
- R5: In 32-device operation `fsync` pulses every 32 cycles. Cycle 0 after `fsync` (even frame) replaces the pool entries of devices 0 to 15, and cycle 16 (odd frame) replaces those of devices 16 to 31. A pooled request stays pending until it is granted or replaced.
- R6: In cycle 15 of every frame, if any request is pending, `grant_vld` is high for exactly that one cycle with exactly one `grant` bit set, and the granted device is removed from the pool. In every other cycle both outputs are zero.
- R7: Device i's priority is `prio[2i+1:2i]`, with 3 the highest and 0 the lowest; a pending request at a higher level always wins over one at a lower level.
- R8: Each priority level has its own round-robin pointer, reset to 0. The winner at a level is the first pending device at that level found by scanning upward from the pointer and wrapping from 31 to 0. The pointer then moves to the winner plus one, modulo 32.
- R9: When no request is pending in cycle 15, `grant_vld` stays low and `grant` is all zeros.
- R10: During and right after reset both outputs are zero, the pool is empty and all pointers are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fsync | input | 1 | Frame sync; high in cycle 0 of a frame (of the even frame in 32-device operation) |
| mode | input | 1 | 0: 16-device operation, 1: 32-device operation |
| req | input | 32 | Request bit per device |
| prio | input | 64 | 2-bit priority per device, device i at bits 2i+1:2i |
| grant | output | 32 | One-hot grant for the next frame, valid in cycle 15 |
| grant_vld | output | 1 | High in cycle 15 when a grant is issued |

## Verification
The hardest situation to reach is a 32-device pool that holds an entry from an earlier half-frame, which must then win or lose against fresh requests from the other half. It also has to keep the right round-robin pointer after a grant has removed a neighbour. The stimulus runs long sequences of even/odd frame pairs with independent random request and priority patterns for each half. Many even-frame entries are therefore still pending at the odd frame's grant, and several levels tie at once. A bench model replays the pool, the removal of each winner and the per-level pointers from the requirements. Separate directed frames drive junk values outside the request cycle and on the upper half in 16-device operation.

// File: rtl/fab_pkg.sv
package fab_pkg;
    typedef enum logic {
        MODE_16 = 1'b0,
        MODE_32 = 1'b1
    } bus_mode_e;
endpackage

// File: rtl/fab_timer.sv
module fab_timer #(
    parameter int unsigned POS_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fsync,
    output logic [POS_W-1:0] pos,
    output logic             active
);
    typedef struct packed {
        logic [POS_W-1:0] cnt;
        logic             synced;
    } tmr_s;

    tmr_s tmr_d, tmr_q;

    // position of the current cycle inside a frame pair
    always_comb begin
        pos          = fsync ? '0 : tmr_q.cnt;
        active       = tmr_q.synced | fsync;
        tmr_d.cnt    = pos + 1'b1;
        tmr_d.synced = active;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end
endmodule

// File: rtl/fab_pick.sv
module fab_pick #(
    parameter int unsigned N_DEV  = 32,
    parameter int unsigned PRIO_W = 2,
    localparam int unsigned IDX_W = $clog2(N_DEV),
    localparam int unsigned LVLS  = 1 << PRIO_W
) (
    input  logic [N_DEV-1:0]        pend,
    input  logic [N_DEV*PRIO_W-1:0] plvl,
    input  logic [LVLS*IDX_W-1:0]   ptr,
    output logic                    found,
    output logic [IDX_W-1:0]        win_idx,
    output logic [PRIO_W-1:0]       win_lvl
);
    logic [LVLS-1:0]       lvl_hit;
    logic [LVLS*IDX_W-1:0] lvl_idx;

    for (genvar l = 0; l < LVLS; l++) begin : g_lvl
        logic [N_DEV-1:0] mask;
        logic [IDX_W-1:0] base;
        logic             hit;
        logic [IDX_W-1:0] idx;

        assign base = ptr[l*IDX_W +: IDX_W];

        for (genvar i = 0; i < N_DEV; i++) begin : g_dev
            assign mask[i] = pend[i] && (plvl[i*PRIO_W +: PRIO_W] == PRIO_W'(l));
        end

        // rotating scan: the smallest offset from the pointer wins
        always_comb begin
            logic [IDX_W-1:0] j;
            hit = 1'b0;
            idx = '0;
            for (int k = N_DEV - 1; k >= 0; k--) begin
                j = base + IDX_W'(k);
                if (mask[j]) begin
                    hit = 1'b1;
                    idx = j;
                end
            end
        end

        assign lvl_hit[l]                = hit;
        assign lvl_idx[l*IDX_W +: IDX_W] = idx;
    end

    // highest level with a hit takes the grant
    always_comb begin
        found   = 1'b0;
        win_idx = '0;
        win_lvl = '0;
        for (int l = 0; l < LVLS; l++) begin
            if (lvl_hit[l]) begin
                found   = 1'b1;
                win_idx = lvl_idx[l*IDX_W +: IDX_W];
                win_lvl = PRIO_W'(l);
            end
        end
    end
endmodule

// File: rtl/frame_arbiter.sv
module frame_arbiter
    import fab_pkg::*;
#(
    parameter int unsigned N_DEV     = 32,
    parameter int unsigned PRIO_W    = 2,
    parameter int unsigned FRAME_LEN = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    fsync,
    input  logic                    mode,
    input  logic [N_DEV-1:0]        req,
    input  logic [N_DEV*PRIO_W-1:0] prio,
    output logic [N_DEV-1:0]        grant,
    output logic                    grant_vld
);
    localparam int unsigned HALF   = N_DEV / 2;
    localparam int unsigned IDX_W  = $clog2(N_DEV);
    localparam int unsigned LVLS   = 1 << PRIO_W;
    localparam int unsigned SLOT_W = $clog2(FRAME_LEN);
    localparam int unsigned POS_W  = SLOT_W + 1;
    localparam int unsigned HP_W   = HALF * PRIO_W;

    typedef struct packed {
        logic [N_DEV-1:0]        pend;
        logic [N_DEV*PRIO_W-1:0] plvl;
        logic [LVLS*IDX_W-1:0]   ptr;
        logic [N_DEV-1:0]        gnt;
        logic                    gv;
    } arb_s;

    arb_s arb_d, arb_q;

    logic [POS_W-1:0]  tmr_pos;
    logic              tmr_active;
    logic              pick_found;
    logic [IDX_W-1:0]  pick_idx;
    logic [PRIO_W-1:0] pick_lvl;
    logic [SLOT_W-1:0] slot;
    logic              odd_half;
    logic              req_cyc;
    logic              pick_cyc;

    fab_timer #(.POS_W(POS_W)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .fsync (fsync),
        .pos   (tmr_pos),
        .active(tmr_active)
    );

    fab_pick #(.N_DEV(N_DEV), .PRIO_W(PRIO_W)) u_pick (
        .pend   (arb_q.pend),
        .plvl   (arb_q.plvl),
        .ptr    (arb_q.ptr),
        .found  (pick_found),
        .win_idx(pick_idx),
        .win_lvl(pick_lvl)
    );

    assign slot     = tmr_pos[SLOT_W-1:0];
    assign odd_half = tmr_pos[SLOT_W];
    assign req_cyc  = tmr_active && (slot == '0);
    // decide one cycle early so the grant is a register in the last cycle
    assign pick_cyc = tmr_active && (slot == SLOT_W'(FRAME_LEN - 2));

    always_comb begin
        arb_d     = arb_q;
        arb_d.gnt = '0;
        arb_d.gv  = 1'b0;

        if (req_cyc) begin
            if (mode == MODE_16) begin
                arb_d.pend[HALF-1:0]         = req[HALF-1:0];
                arb_d.plvl[HP_W-1:0]         = prio[HP_W-1:0];
                arb_d.pend[N_DEV-1:HALF]     = '0;
                arb_d.plvl[2*HP_W-1:HP_W]    = '0;
            end else if (!odd_half) begin
                arb_d.pend[HALF-1:0]         = req[HALF-1:0];
                arb_d.plvl[HP_W-1:0]         = prio[HP_W-1:0];
            end else begin
                arb_d.pend[N_DEV-1:HALF]     = req[N_DEV-1:HALF];
                arb_d.plvl[2*HP_W-1:HP_W]    = prio[2*HP_W-1:HP_W];
            end
        end

        if (pick_cyc && pick_found) begin
            arb_d.gnt[pick_idx]  = 1'b1;
            arb_d.gv             = 1'b1;
            arb_d.pend[pick_idx] = 1'b0;
            arb_d.ptr[int'(pick_lvl)*IDX_W +: IDX_W] = pick_idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) arb_q <= '0;
        else        arb_q <= arb_d;
    end

    assign grant     = arb_q.gnt;
    assign grant_vld = arb_q.gv;
endmodule

// File: rtl/fab_chk.sv
module fab_chk #(
    parameter int unsigned N_DEV  = 32,
    parameter int unsigned POS_W  = 5,
    parameter int unsigned SLOT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mode,
    input logic [N_DEV-1:0] grant,
    input logic             grant_vld,
    input logic [POS_W-1:0] pos,
    input logic             active
);
    localparam int unsigned HALF = N_DEV / 2;

    // R6: never more than one device granted
    p_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R9: grant vector non-zero exactly when the valid flag is up
    p_vld_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
        grant_vld == (grant != '0));

    // R6: a grant lasts a single cycle
    p_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        grant_vld |=> !grant_vld);

    // R6: a grant is only seen in the last cycle of a frame
    p_last_slot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        grant_vld |-> (pos[SLOT_W-1:0] == {SLOT_W{1'b1}}));

    // R2: nothing is granted before frame sync has been seen
    p_no_sync_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !grant_vld);

    // R4: upper devices never win in 16-device operation
    p_upper_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_vld && !mode && !$past(mode)) |-> (grant[N_DEV-1:HALF] == '0));
endmodule

bind frame_arbiter fab_chk #(.N_DEV(N_DEV), .POS_W(POS_W), .SLOT_W(SLOT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .grant    (grant),
    .grant_vld(grant_vld),
    .pos      (tmr_pos),
    .active   (tmr_active)
);

// File: tb/sim_frame_arbiter.sv
module sim_frame_arbiter;
    localparam int N  = 32;
    localparam int H  = 16;
    localparam int PW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fsync = 1'b0;
    logic          mode = 1'b0;
    logic [N-1:0]  req = '0;
    logic [2*N-1:0] prio = '0;
    logic [N-1:0]  grant;
    logic          grant_vld;

    int total = 0;
    int bad   = 0;

    bit m_pend [N];
    int m_lvl  [N];
    int m_ptr  [4];

    frame_arbiter u0 (
        .clk(clk), .rst_n(rst_n), .fsync(fsync), .mode(mode),
        .req(req), .prio(prio), .grant(grant), .grant_vld(grant_vld)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input logic [N-1:0] eg, input logic ev);
        total++;
        if (grant !== eg || grant_vld !== ev) begin
            bad++;
            $display("FAIL %s: grant=%h vld=%b expected grant=%h vld=%b",
                     tag, grant, grant_vld, eg, ev);
        end
    endtask

    task automatic model_pick(output logic [N-1:0] eg, output logic ev);
        int best = -1;
        int win  = -1;
        eg = '0;
        ev = 1'b0;
        for (int i = 0; i < N; i++)
            if (m_pend[i] && m_lvl[i] > best) best = m_lvl[i];
        if (best >= 0) begin
            for (int k = 0; k < N; k++) begin
                int j = (m_ptr[best] + k) % N;
                if (win < 0 && m_pend[j] && m_lvl[j] == best) win = j;
            end
            eg[win]      = 1'b1;
            ev           = 1'b1;
            m_pend[win]  = 1'b0;
            m_ptr[best]  = (win + 1) % N;
        end
    endtask

    // called at the negedge inside cycle 0 of a frame; returns at the next frame's cycle 0
    task automatic run_frame(input bit sync, input bit odd, input logic [N-1:0] r,
                             input logic [2*N-1:0] p, input logic [N-1:0] r_junk,
                             input string tag);
        logic [N-1:0] eg;
        logic         ev;
        fsync = sync;
        req   = r;
        prio  = p;
        for (int i = 0; i < N; i++) begin
            bit lower = (i < H);
            if (!mode) begin
                m_pend[i] = lower ? r[i] : 1'b0;
                m_lvl[i]  = lower ? int'(p[2*i +: 2]) : 0;
            end else if (lower != odd) begin
                m_pend[i] = r[i];
                m_lvl[i]  = int'(p[2*i +: 2]);
            end
        end
        @(negedge clk);
        fsync = 1'b0;
        req   = r_junk;
        prio  = ~p;
        repeat (7) @(negedge clk);
        chk({tag, " R6 mid-frame"}, '0, 1'b0);
        repeat (7) @(negedge clk);
        model_pick(eg, ev);
        chk(tag, eg, ev);
        @(negedge clk);
    endtask

    function automatic logic [2*N-1:0] rnd64();
        return {$urandom, $urandom};
    endfunction

    initial begin
        #(20 * 150000);
        total++;
        bad++;
        $display("FAIL watchdog: run hung, expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        bit seen;
        logic [2*N-1:0] pv;
        for (int i = 0; i < N; i++) begin m_pend[i] = 0; m_lvl[i] = 0; end
        for (int l = 0; l < 4; l++) m_ptr[l] = 0;

        repeat (3) @(negedge clk);
        chk("R10 reset", '0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 after reset", '0, 1'b0);

        // R2: no frame sync yet, requests held high
        req  = '1;
        prio = '1;
        seen = 1'b0;
        repeat (40) begin
            @(negedge clk);
            if (grant_vld) seen = 1'b1;
        end
        total++;
        if (seen) begin
            bad++;
            $display("FAIL R2 grant before sync: got 1 expected 0");
        end

        // R1 R8: 16-device operation, all equal priority, rotating grants
        mode = 1'b0;
        for (int f = 0; f < 20; f++)
            run_frame(1, 0, 32'h0000_FFFF, '0, '1, "R1 R8 rotate");

        // R7: one device at level 3 beats the rest at level 1
        pv = '0;
        for (int i = 0; i < H; i++) pv[2*i +: 2] = 2'd1;
        pv[2*5 +: 2] = 2'd3;
        for (int f = 0; f < 4; f++)
            run_frame(1, 0, 32'h0000_FFFF, pv, '0, "R7 level");

        // R9: nothing pending
        for (int f = 0; f < 2; f++)
            run_frame(1, 0, '0, rnd64(), '0, "R9 empty");

        // R4: only upper inputs requesting in 16-device operation
        for (int f = 0; f < 2; f++)
            run_frame(1, 0, 32'hFFFF_0000, '1, 32'hFFFF_0000, "R4 upper ignored");

        // R3: requests only outside the request cycle
        for (int f = 0; f < 2; f++)
            run_frame(1, 0, '0, '1, '1, "R3 off-cycle ignored");

        // R7 R8: random 16-device frames
        for (int f = 0; f < 150; f++)
            run_frame(1, 0, $urandom, rnd64(), $urandom, "R7 R8 random16");

        // R5: directed pair, lower then upper
        mode = 1'b1;
        pv = '0;
        pv[2*3 +: 2]  = 2'd2;
        pv[2*20 +: 2] = 2'd3;
        run_frame(1, 0, 32'h0000_0008, pv, '1, "R5 even");
        run_frame(0, 1, 32'h0010_0000, pv, '1, "R5 odd");

        // R5 R7 R8: random 32-device frame pairs, pooled entries survive
        for (int f = 0; f < 150; f++) begin
            run_frame(1, 0, $urandom, rnd64(), $urandom, "R5 random even");
            run_frame(0, 1, $urandom, rnd64(), $urandom, "R5 random odd");
        end

        // R1: back to 16-device operation
        mode = 1'b0;
        for (int f = 0; f < 20; f++)
            run_frame(1, 0, $urandom, rnd64(), $urandom, "R1 back to 16");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule